// File: doc/BRIEF.md
# Serial Flash FIFO Status and Interrupt Unit

This block holds the byte queues between a register bus and a serial flash shift engine. Two FIFOs of 256 bytes each are provided. Software writes bytes into the transmit queue through a 16-bit data port, and the shift engine pops them from that queue. The engine pushes received bytes into the receive queue, and software pops them by reading the same data port.

Around the queues the unit reports status flags and two programmable watermarks. It raises four interrupt causes: receive overrun, receive idle timeout, receive level reached and transmit level low. Each cause can be masked, and the sticky causes are cleared by writing ones. The enabled causes are combined into one interrupt line.

Software uses the block as follows. It loads the command header and any transmit data, then polls the status or waits for the interrupt. It drains the receive queue while the receive-not-empty flag is set.

Top module: `serflash_fifo_irq`

## Requirements
- R1: After reset the status word reads 0x0003, the threshold word reads 0x2020, the mask reads 0, the raw interrupt word reads 0x0008 and `irq` is low.
- R2: A write to register 0 (data) pushes bits 7:0 into the transmit queue. The engine sees the bytes in write order on `sh_tx_data`, with `sh_tx_valid` high while the queue holds data. A write to a full transmit queue is discarded.
- R3: Status word (register 1): bit 0 is transmit empty, bit 1 is transmit not full, bit 2 is receive not empty, bit 3 is receive full. Bits 15:5 read 0.
- R4: A read of register 0 returns the oldest receive byte in bits 7:0, with zeros above, and removes it. A read of an empty receive queue returns 0 and changes nothing.
- R5: Each queue holds exactly 256 bytes. The receive-full flag rises on the 256th stored byte.
- R6: Raw bit 0 (overrun) is set when the engine pushes while the receive queue is full and no pop occurs in the same cycle. That byte is discarded. The bit holds until a 1 is written to bit 0 of register 6 (clear). If an overrun and that clear write fall in the same cycle, the bit stays set.
- R7: An engine push and a software pop in the same cycle on a full receive queue are both accepted. The queue stays full and no overrun is raised.
- R8: The threshold register (register 2) holds the receive watermark in bits 14:8 and the transmit watermark in bits 6:0. Both reset to 32. Bits 15 and 7 read 0.
- R9: Raw bit 2 is high while receive occupancy is at least the receive watermark. Raw bit 3 is high while transmit occupancy is at most the transmit watermark. The raw word is register 4.
- R10: Raw bit 1 (timeout) is set on the 32nd `sclk_tick` pulse during which the receive queue is non-empty with no push or pop since the count began. A receive push or pop clears it and restarts the count. Writing 1 to bit 1 of register 6 clears it and restarts the count. Ticks while the queue is empty do not count.
- R11: Register 5 reads the raw word ANDed with the mask (register 3, bits 3:0). `irq` is high exactly when that masked word is non-zero.
- R12: Status bit 4 (busy) is high while `sh_busy` is high or the transmit queue is non-empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; pops the receive queue when addressing register 0 |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, valid in the same cycle |
| sh_tx_pop | input | 1 | Engine takes the head transmit byte |
| sh_tx_data | output | 8 | Head of the transmit queue |
| sh_tx_valid | output | 1 | Transmit queue holds data |
| sh_rx_push | input | 1 | Engine delivers a received byte |
| sh_rx_data | input | 8 | Received byte |
| sh_busy | input | 1 | Engine is mid-transfer |
| sclk_tick | input | 1 | One pulse per serial clock period |
| irq | output | 1 | Combined masked interrupt |

## Verification
The receive queue has two writers of state that can act in the same cycle: the engine's push and software's pop or clear. The bench fills the receive queue to 256 bytes. It then drives an engine push and a data-port read on the same clock edge, and expects full to persist, no overrun, and the new byte to come out last when the queue is drained. In a second step it raises an overrun push and a clear write on the same edge. The overrun bit must then survive, and a later clear alone must drop it.

// File: rtl/sfq_pkg.sv
package sfq_pkg;
   typedef enum logic [2:0] {
      A_DATA = 3'd0,
      A_STAT = 3'd1,
      A_THR  = 3'd2,
      A_MASK = 3'd3,
      A_RAW  = 3'd4,
      A_MSKD = 3'd5,
      A_CLR  = 3'd6
   } sfq_addr_e;

   localparam int ST_TXE  = 0;
   localparam int ST_TXNF = 1;
   localparam int ST_RXNE = 2;
   localparam int ST_RXF  = 3;
   localparam int ST_BSY  = 4;
   localparam int NSTAT   = 5;

   localparam int IR_OVR = 0;
   localparam int IR_TMO = 1;
   localparam int IR_RXW = 2;
   localparam int IR_TXW = 3;
   localparam int NIRQ   = 4;
endpackage

// File: rtl/sfq_fifo.sv
module sfq_fifo #(
   parameter int DW    = 8,
   parameter int DEPTH = 256,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [DW-1:0] wdata,
   input  logic          pop,
   output logic [DW-1:0] rdata,
   output logic [CW-1:0] count,
   output logic          empty,
   output logic          full
);
   generate
      if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
         $error("sfq_fifo: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic          do_push, do_pop;

   assign empty   = (count == '0);
   assign full    = (count == CW'(DEPTH));
   assign do_pop  = pop && !empty;
   assign do_push = push && (!full || do_pop);
   assign rdata   = mem[rp];

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop)  rp <= rp + 1'b1;
         if (do_push && !do_pop)      count <= count + 1'b1;
         else if (do_pop && !do_push) count <= count - 1'b1;
      end
   end
endmodule

// File: rtl/sfq_timeout.sv
module sfq_timeout #(
   parameter int TICKS = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic rx_push,
   input  logic rx_pop,
   input  logic rx_empty,
   input  logic clr,
   output logic flag
);
   generate
      if (TICKS == 0) begin : g_off
         logic unused_tmo_in;
         assign unused_tmo_in = ^{tick, rx_push, rx_pop, rx_empty, clr, clk, rst_n};
         assign flag = 1'b0;
      end else begin : g_on
         localparam int TW = $clog2(TICKS + 1);
         logic [TW-1:0] cnt;
         logic          quiet, hit;

         assign quiet = !rx_push && !rx_pop && !rx_empty;
         assign hit   = tick && quiet && (cnt == TW'(TICKS - 1));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt  <= '0;
               flag <= 1'b0;
            end else begin
               if (!quiet)                          cnt <= '0;
               else if (hit)                        cnt <= TW'(TICKS);
               else if (clr)                        cnt <= '0;
               else if (tick && cnt != TW'(TICKS))  cnt <= cnt + 1'b1;

               if (hit)                             flag <= 1'b1;
               else if (clr || rx_push || rx_pop)   flag <= 1'b0;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/sfq_irq.sv
module sfq_irq
   import sfq_pkg::*;
#(
   parameter int CW   = 9,
   parameter int WM_W = 7
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ovr_evt,
   input  logic            clr_ovr,
   input  logic            tmo_flag,
   input  logic [CW-1:0]   rx_count,
   input  logic [CW-1:0]   tx_count,
   input  logic [WM_W-1:0] wm_rx,
   input  logic [WM_W-1:0] wm_tx,
   input  logic [NIRQ-1:0] mask,
   output logic [NIRQ-1:0] raw,
   output logic [NIRQ-1:0] masked,
   output logic            irq
);
   generate
      if (WM_W > CW) begin : g_bad_wm
         $error("sfq_irq: watermark wider than occupancy count");
      end
   endgenerate

   logic ovr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ovr_q <= 1'b0;
      else if (ovr_evt) ovr_q <= 1'b1;
      else if (clr_ovr) ovr_q <= 1'b0;
   end

   always_comb begin
      raw         = '0;
      raw[IR_OVR] = ovr_q;
      raw[IR_TMO] = tmo_flag;
      raw[IR_RXW] = (rx_count >= CW'(wm_rx));
      raw[IR_TXW] = (tx_count <= CW'(wm_tx));
   end

   assign masked = raw & mask;
   assign irq    = |masked;
endmodule

// File: rtl/serflash_fifo_irq.sv
module serflash_fifo_irq
   import sfq_pkg::*;
#(
   parameter int DEPTH     = 256,
   parameter int WM_W      = 7,
   parameter int WM_RESET  = 32,
   parameter int TMO_TICKS = 32
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr,
   input  logic        reg_rd,
   input  logic [2:0]  reg_addr,
   input  logic [15:0] reg_wdata,
   output logic [15:0] reg_rdata,
   input  logic        sh_tx_pop,
   output logic [7:0]  sh_tx_data,
   output logic        sh_tx_valid,
   input  logic        sh_rx_push,
   input  logic [7:0]  sh_rx_data,
   input  logic        sh_busy,
   input  logic        sclk_tick,
   output logic        irq
);
   localparam int CW = $clog2(DEPTH + 1);

   generate
      if (WM_W < 1 || WM_W > 7) begin : g_bad_wmw
         $error("serflash_fifo_irq: WM_W must be 1..7");
      end
      if (WM_RESET < 0 || WM_RESET >= (1 << WM_W)) begin : g_bad_wmr
         $error("serflash_fifo_irq: WM_RESET does not fit WM_W bits");
      end
   endgenerate

   logic [CW-1:0]   rx_count, tx_count;
   logic            rx_empty, rx_full, tx_empty, tx_full;
   logic [7:0]      rx_head;
   logic            rx_pop, tx_push, clr_wr;
   logic [WM_W-1:0] wm_rx, wm_tx;
   logic [NIRQ-1:0] mask, raw_word, masked_word;
   logic [NSTAT-1:0] stat;
   logic            tmo_flag, ovr_evt;
   logic            unused_hi;

   assign unused_hi = reg_wdata[15];

   assign tx_push = reg_wr && (reg_addr == A_DATA);
   assign rx_pop  = reg_rd && (reg_addr == A_DATA) && !rx_empty;
   assign clr_wr  = reg_wr && (reg_addr == A_CLR);
   assign ovr_evt = sh_rx_push && rx_full && !rx_pop;

   sfq_fifo #(.DW(8), .DEPTH(DEPTH)) u_txq (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (tx_push),
      .wdata (reg_wdata[7:0]),
      .pop   (sh_tx_pop),
      .rdata (sh_tx_data),
      .count (tx_count),
      .empty (tx_empty),
      .full  (tx_full)
   );

   sfq_fifo #(.DW(8), .DEPTH(DEPTH)) u_rxq (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (sh_rx_push),
      .wdata (sh_rx_data),
      .pop   (rx_pop),
      .rdata (rx_head),
      .count (rx_count),
      .empty (rx_empty),
      .full  (rx_full)
   );

   sfq_timeout #(.TICKS(TMO_TICKS)) u_tmo (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (sclk_tick),
      .rx_push  (sh_rx_push),
      .rx_pop   (rx_pop),
      .rx_empty (rx_empty),
      .clr      (clr_wr && reg_wdata[IR_TMO]),
      .flag     (tmo_flag)
   );

   sfq_irq #(.CW(CW), .WM_W(WM_W)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .ovr_evt  (ovr_evt),
      .clr_ovr  (clr_wr && reg_wdata[IR_OVR]),
      .tmo_flag (tmo_flag),
      .rx_count (rx_count),
      .tx_count (tx_count),
      .wm_rx    (wm_rx),
      .wm_tx    (wm_tx),
      .mask     (mask),
      .raw      (raw_word),
      .masked   (masked_word),
      .irq      (irq)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wm_rx <= WM_W'(WM_RESET);
         wm_tx <= WM_W'(WM_RESET);
         mask  <= '0;
      end else if (reg_wr) begin
         if (reg_addr == A_THR) begin
            wm_rx <= reg_wdata[8 +: WM_W];
            wm_tx <= reg_wdata[0 +: WM_W];
         end
         if (reg_addr == A_MASK) mask <= reg_wdata[NIRQ-1:0];
      end
   end

   always_comb begin
      stat          = '0;
      stat[ST_TXE]  = tx_empty;
      stat[ST_TXNF] = !tx_full;
      stat[ST_RXNE] = !rx_empty;
      stat[ST_RXF]  = rx_full;
      stat[ST_BSY]  = sh_busy || !tx_empty;
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         A_DATA: if (!rx_empty) reg_rdata[7:0] = rx_head;
         A_STAT: reg_rdata[NSTAT-1:0] = stat;
         A_THR: begin
            reg_rdata[8 +: WM_W] = wm_rx;
            reg_rdata[0 +: WM_W] = wm_tx;
         end
         A_MASK: reg_rdata[NIRQ-1:0] = mask;
         A_RAW:  reg_rdata[NIRQ-1:0] = raw_word;
         A_MSKD: reg_rdata[NIRQ-1:0] = masked_word;
         default: reg_rdata = '0;
      endcase
   end

   assign sh_tx_valid = !tx_empty;
endmodule

// File: rtl/sfq_checker.sv
module sfq_checker #(
   parameter int DEPTH = 256,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          rx_push,
   input logic          rx_pop,
   input logic          rx_full,
   input logic [CW-1:0] rx_count,
   input logic [3:0]    raw,
   input logic          clr_wr,
   input logic [15:0]   wdata,
   input logic          tick
);
   assert_ovr_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(raw[0]) |-> $past(rx_push && rx_full && !rx_pop));

   assert_ovr_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (raw[0] && !(clr_wr && wdata[0])) |=> raw[0]);

   assert_rx_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rx_count <= CW'(DEPTH));

   assert_full_swap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_push && rx_pop && rx_full) |=> (rx_full && !$rose(raw[0])));

   assert_rx_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_count == $past(rx_count)) || (rx_count == $past(rx_count) + 1'b1) ||
      (rx_count + 1'b1 == $past(rx_count)));

   assert_tmo_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(raw[1]) |-> $past(tick));
endmodule

bind serflash_fifo_irq sfq_checker #(.DEPTH(DEPTH)) u_sfq_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .rx_push  (sh_rx_push),
   .rx_pop   (rx_pop),
   .rx_full  (rx_full),
   .rx_count (rx_count),
   .raw      (raw_word),
   .clr_wr   (clr_wr),
   .wdata    (reg_wdata),
   .tick     (sclk_tick)
);

// File: tb/test_serflash_fifo_irq.sv
module test_serflash_fifo_irq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        sh_tx_pop = 1'b0;
   logic [7:0]  sh_tx_data;
   logic        sh_tx_valid;
   logic        sh_rx_push = 1'b0;
   logic [7:0]  sh_rx_data = '0;
   logic        sh_busy = 1'b0;
   logic        sclk_tick = 1'b0;
   logic        irq;

   int checks = 0;
   int fails  = 0;

   localparam logic [2:0] RA_DATA = 3'd0, RA_STAT = 3'd1, RA_THR = 3'd2,
                          RA_MASK = 3'd3, RA_RAW = 3'd4, RA_MSKD = 3'd5, RA_CLR = 3'd6;

   always #10 clk = ~clk;

   serflash_fifo_irq i_serflash_fifo_irq (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sh_tx_pop(sh_tx_pop),
      .sh_tx_data(sh_tx_data), .sh_tx_valid(sh_tx_valid), .sh_rx_push(sh_rx_push),
      .sh_rx_data(sh_rx_data), .sh_busy(sh_busy), .sclk_tick(sclk_tick), .irq(irq)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      reg_wr = 0; reg_rd = 0; sh_tx_pop = 0; sh_rx_push = 0; sh_busy = 0; sclk_tick = 0;
      rst_n = 0;
      repeat (2) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      reg_addr = a; reg_wdata = d; reg_wr = 1;
      @(negedge clk);
      reg_wr = 0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [15:0] v);
      reg_addr = a; reg_rd = 1;
      #1 v = reg_rdata;
      @(negedge clk);
      reg_rd = 0;
   endtask

   task automatic rx_push(input logic [7:0] b);
      sh_rx_data = b; sh_rx_push = 1;
      @(negedge clk);
      sh_rx_push = 0;
   endtask

   task automatic tx_pop();
      sh_tx_pop = 1;
      @(negedge clk);
      sh_tx_pop = 0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         sclk_tick = 1;
         @(negedge clk);
         sclk_tick = 0;
      end
   endtask

   task automatic t_reset();
      logic [15:0] v;
      do_reset();
      rd(RA_STAT, v); check("R1 status", v, 16'h0003);
      rd(RA_THR, v);  check("R1 thresholds", v, 16'h2020);
      rd(RA_MASK, v); check("R1 mask", v, 16'h0000);
      rd(RA_RAW, v);  check("R1 raw", v, 16'h0008);
      check("R1 irq", {15'd0, irq}, 16'h0000);
   endtask

   task automatic t_tx_path();
      logic [15:0] v;
      do_reset();
      wr(RA_DATA, 16'h01A5); wr(RA_DATA, 16'h003C); wr(RA_DATA, 16'hFFFF);
      rd(RA_STAT, v); check("R3 R12 status with tx data", v, 16'h0012);
      check("R2 valid", {15'd0, sh_tx_valid}, 16'h0001);
      check("R2 byte0", {8'd0, sh_tx_data}, 16'h00A5); tx_pop();
      check("R2 byte1", {8'd0, sh_tx_data}, 16'h003C); tx_pop();
      check("R2 byte2", {8'd0, sh_tx_data}, 16'h00FF); tx_pop();
      check("R2 drained", {15'd0, sh_tx_valid}, 16'h0000);
      rd(RA_STAT, v); check("R3 idle status", v, 16'h0003);
      sh_busy = 1;
      rd(RA_STAT, v); check("R12 busy from engine", v, 16'h0013);
      sh_busy = 0;
   endtask

   task automatic t_tx_full();
      logic [15:0] v;
      int bad = 0;
      do_reset();
      for (int i = 0; i < 256; i++) wr(RA_DATA, 16'(i));
      rd(RA_STAT, v); check("R5 R3 tx full status", v, 16'h0010);
      rd(RA_RAW, v);  check("R9 tx watermark off when full", v & 16'h0008, 16'h0000);
      wr(RA_DATA, 16'h0077);
      for (int i = 0; i < 256; i++) begin
         if (sh_tx_data !== 8'(i)) bad++;
         tx_pop();
      end
      check("R2 order after full, extra write dropped", 16'(bad), 16'h0000);
      check("R2 no extra byte", {15'd0, sh_tx_valid}, 16'h0000);
   endtask

   task automatic t_rx_path();
      logic [15:0] v;
      do_reset();
      rx_push(8'h11); rx_push(8'h22); rx_push(8'h33);
      rd(RA_STAT, v); check("R3 rx not empty", v, 16'h0007);
      rd(RA_DATA, v); check("R4 rx byte0", v, 16'h0011);
      rd(RA_DATA, v); check("R4 rx byte1", v, 16'h0022);
      rd(RA_DATA, v); check("R4 rx byte2", v, 16'h0033);
      rd(RA_DATA, v); check("R4 empty read", v, 16'h0000);
      rd(RA_STAT, v); check("R4 empty read no effect", v, 16'h0003);
   endtask

   task automatic t_rx_full_overrun();
      logic [15:0] v;
      int bad = 0;
      do_reset();
      for (int i = 0; i < 255; i++) rx_push(8'(i));
      rd(RA_STAT, v); check("R5 not full at 255", v & 16'h0008, 16'h0000);
      rx_push(8'd255);
      rd(RA_STAT, v); check("R5 full at 256", v, 16'h000F);
      // R7: simultaneous push and pop on full queue
      sh_rx_data = 8'hD0; sh_rx_push = 1; reg_addr = RA_DATA; reg_rd = 1;
      #1 v = reg_rdata;
      @(negedge clk);
      sh_rx_push = 0; reg_rd = 0;
      check("R7 popped head", v, 16'h0000);
      rd(RA_STAT, v); check("R7 still full", v & 16'h0008, 16'h0008);
      rd(RA_RAW, v);  check("R7 no overrun", v & 16'h0001, 16'h0000);
      rx_push(8'hEE);
      rd(RA_RAW, v);  check("R6 overrun set", v & 16'h0001, 16'h0001);
      rx_push(8'hEF);
      rd(RA_RAW, v);  check("R6 overrun sticky", v & 16'h0001, 16'h0001);
      // R6: overrun and clear in the same cycle, set wins
      sh_rx_data = 8'hEA; sh_rx_push = 1; reg_addr = RA_CLR; reg_wdata = 16'h0001; reg_wr = 1;
      @(negedge clk);
      sh_rx_push = 0; reg_wr = 0;
      rd(RA_RAW, v);  check("R6 set wins over clear", v & 16'h0001, 16'h0001);
      wr(RA_CLR, 16'h0001);
      rd(RA_RAW, v);  check("R6 cleared", v & 16'h0001, 16'h0000);
      for (int i = 1; i < 256; i++) begin
         rd(RA_DATA, v);
         if (v !== 16'(i)) bad++;
      end
      rd(RA_DATA, v);
      if (v !== 16'h00D0) bad++;
      check("R6 R7 drain order, overrun bytes discarded", 16'(bad), 16'h0000);
      rd(RA_STAT, v); check("R5 empty after drain", v, 16'h0003);
   endtask

   task automatic t_watermark();
      logic [15:0] v;
      do_reset();
      wr(RA_THR, 16'hFFFF);
      rd(RA_THR, v); check("R8 field layout", v, 16'h7F7F);
      wr(RA_THR, 16'h0201);
      rd(RA_THR, v); check("R8 readback", v, 16'h0201);
      rd(RA_RAW, v); check("R9 empty queues", v, 16'h0008);
      rx_push(8'h01);
      rd(RA_RAW, v); check("R9 rx below watermark", v & 16'h0004, 16'h0000);
      rx_push(8'h02);
      rd(RA_RAW, v); check("R9 rx at watermark", v & 16'h0004, 16'h0004);
      wr(RA_DATA, 16'h0005); wr(RA_DATA, 16'h0006);
      rd(RA_RAW, v); check("R9 tx above watermark", v & 16'h0008, 16'h0000);
      tx_pop();
      rd(RA_RAW, v); check("R9 tx at watermark", v & 16'h0008, 16'h0008);
   endtask

   task automatic t_irq();
      logic [15:0] v;
      do_reset();
      wr(RA_MASK, 16'h0008);
      rd(RA_MSKD, v); check("R11 masked tx cause", v, 16'h0008);
      check("R11 irq on", {15'd0, irq}, 16'h0001);
      wr(RA_MASK, 16'h0007);
      rd(RA_MSKD, v); check("R11 masked none", v, 16'h0000);
      check("R11 irq off", {15'd0, irq}, 16'h0000);
      rd(RA_RAW, v); check("R11 raw unaffected by mask", v, 16'h0008);
   endtask

   task automatic t_timeout();
      logic [15:0] v;
      do_reset();
      ticks(40);
      rx_push(8'h5A);
      ticks(31);
      rd(RA_RAW, v); check("R10 no timeout at 31, empty ticks ignored", v & 16'h0002, 16'h0000);
      ticks(1);
      rd(RA_RAW, v); check("R10 timeout at 32", v & 16'h0002, 16'h0002);
      rd(RA_DATA, v); check("R4 timeout byte", v, 16'h005A);
      rd(RA_RAW, v); check("R10 pop clears", v & 16'h0002, 16'h0000);
      rx_push(8'h01); rx_push(8'h02);
      ticks(32);
      rd(RA_RAW, v); check("R10 timeout again", v & 16'h0002, 16'h0002);
      wr(RA_CLR, 16'h0002);
      rd(RA_RAW, v); check("R10 clear write", v & 16'h0002, 16'h0000);
      ticks(20);
      rx_push(8'h03);
      ticks(31);
      rd(RA_RAW, v); check("R10 push restarts count", v & 16'h0002, 16'h0000);
      ticks(1);
      rd(RA_RAW, v); check("R10 timeout after restart", v & 16'h0002, 16'h0002);
      rx_push(8'h04);
      rd(RA_RAW, v); check("R10 push clears", v & 16'h0002, 16'h0000);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_tx_path();
      t_tx_full();
      t_rx_path();
      t_rx_full_overrun();
      t_watermark();
      t_irq();
      t_timeout();
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule